// File: doc/BRIEF.md
# Store Miss Merging Buffer

This block sits between a load/store unit and a data cache. It collects store operations that missed the cache. Later misses that fall in the same 32-byte line are folded into the entry already open for that line. Each entry records which bytes of its line have been written. The buffer holds up to eight lines at once, so up to eight misses can be outstanding. The responses from the next memory level may come back in any order.

When draining is enabled, the buffer sends a request downstream for the lowest-numbered entry that has not yet been requested. The request carries the entry number as its tag. If the stores have covered all 32 bytes, the request is marked address-only: only ownership is needed and no data phase. Otherwise the request is a fill. When the response arrives, the fill bytes are placed only under the bytes that were never written. The finished line is then presented one cycle later, and the entry is released at that point.

Top module: `smb_top`

## Requirements
- R1: After reset, no entry is held, and `req_valid`, `done_valid` and `st_stall` are all low.
- R2: A store whose line matches no entry allocates the lowest-numbered free entry. That entry number becomes the tag of its later request.
- R3: A store whose line matches a held entry merges its enabled bytes (bit k of `st_be` enables byte k, held in `st_data[8k+7:8k]`) into that entry. It creates no second entry and no second request.
- R4: Where two merged stores write the same byte, the later store's byte is kept.
- R5: A request for an entry whose 32 bytes have all been written has `req_addr_only` = 1.
- R6: A request for a partly written entry has `req_addr_only` = 0. The returned line takes the written bytes from the stores and every other byte from `rsp_data`.
- R7: For an address-only entry, `rsp_data` has no effect: the returned line is the store data alone.
- R8: `st_stall` is high exactly when a store matches no held entry and no entry is free. A store that hits a held line is accepted even when all entries are in use. A stalled store changes nothing.
- R9: Responses may return in any order. Each one produces the line and tag of the entry named by `rsp_tag`.
- R10: `req_valid` is low while `drain_en` is low. While `drain_en` is high, requests go out in ascending entry order, one per accepted `req_ready` cycle.
- R11: `done_valid` rises in the cycle after `rsp_valid`, and the entry can be allocated again from then on.
- R12: No two held entries ever hold the same line address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store miss present |
| st_line | input | LINE_AW | Line address of the store |
| st_be | input | 32 | Byte enables within the line |
| st_data | input | 256 | Store data, aligned to the line |
| st_stall | output | 1 | Store cannot be taken this cycle |
| drain_en | input | 1 | Allow downstream requests |
| req_valid | output | 1 | Request offered downstream |
| req_ready | input | 1 | Request taken downstream |
| req_tag | output | TAG_W | Entry number of the request |
| req_line | output | LINE_AW | Line address of the request |
| req_addr_only | output | 1 | Ownership only, no data phase |
| rsp_valid | input | 1 | Response from downstream |
| rsp_tag | input | TAG_W | Entry the response belongs to |
| rsp_data | input | 256 | Fill data (ignored for address-only) |
| done_valid | output | 1 | Completed line available |
| done_tag | output | TAG_W | Entry that completed |
| done_line | output | LINE_AW | Line address of the completed line |
| done_data | output | 256 | Merged line data |

## Verification
On every cycle, the assertions check the following:
- line addresses stay unique across entries, and at most one entry hits;
- a stall appears only when every entry is in use;
- allocation and merging target only free and held entries respectively;
- a response refers to an issued entry, and the completed output follows it by one cycle.

Only the bench's scenarios can show the rest. That covers the byte-level result of merging: later bytes override earlier ones, and fill bytes land only where no store wrote. It also covers the choice between address-only and fill requests, the tag assigned at allocation, and the recovery of an entry after out-of-order responses.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int LINE_BYTES = 32;
  localparam int LINE_BITS  = LINE_BYTES * 8;

  // overlay the enabled bytes of upd onto base
  function automatic logic [LINE_BITS-1:0] overlay_bytes(
    input logic [LINE_BITS-1:0]  base,
    input logic [LINE_BITS-1:0]  upd,
    input logic [LINE_BYTES-1:0] en);
    logic [LINE_BITS-1:0] r;
    r = base;
    for (int b = 0; b < LINE_BYTES; b++)
      if (en[b]) r[8*b +: 8] = upd[8*b +: 8];
    return r;
  endfunction

  function automatic logic line_complete(input logic [LINE_BYTES-1:0] m);
    return &m;
  endfunction
endpackage

// File: rtl/smb_pick.sv
module smb_pick #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/smb_entry.sv
module smb_entry
  import smb_pkg::*;
#(
  parameter int LINE_AW = 27
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc,
  input  logic                  merge,
  input  logic                  issue,
  input  logic                  retire,
  input  logic [LINE_AW-1:0]    in_line,
  input  logic [LINE_BYTES-1:0] in_be,
  input  logic [LINE_BITS-1:0]  in_data,
  output logic                  q_valid,
  output logic                  q_issued,
  output logic [LINE_AW-1:0]    q_line,
  output logic [LINE_BYTES-1:0] q_mask,
  output logic [LINE_BITS-1:0]  q_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_issued <= 1'b0;
      q_line   <= '0;
      q_mask   <= '0;
      q_data   <= '0;
    end else begin
      if (retire) begin
        q_valid  <= 1'b0;
        q_issued <= 1'b0;
      end
      if (alloc) begin
        q_valid  <= 1'b1;
        q_issued <= 1'b0;
        q_line   <= in_line;
        q_mask   <= in_be;
        q_data   <= overlay_bytes('0, in_data, in_be);
      end else if (merge) begin
        q_mask   <= q_mask | in_be;
        q_data   <= overlay_bytes(q_data, in_data, in_be);
      end
      if (issue) q_issued <= 1'b1;
    end
  end

  AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !q_valid); // R2
  AST_MERGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    merge |-> q_valid); // R3
  AST_ISSUE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (q_valid && !q_issued)); // R10
endmodule

// File: rtl/smb_top.sv
module smb_top
  import smb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int LINE_AW     = 27,
  localparam int TAG_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_valid,
  input  logic [LINE_AW-1:0]    st_line,
  input  logic [LINE_BYTES-1:0] st_be,
  input  logic [LINE_BITS-1:0]  st_data,
  output logic                  st_stall,
  input  logic                  drain_en,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic [TAG_W-1:0]      req_tag,
  output logic [LINE_AW-1:0]    req_line,
  output logic                  req_addr_only,
  input  logic                  rsp_valid,
  input  logic [TAG_W-1:0]      rsp_tag,
  input  logic [LINE_BITS-1:0]  rsp_data,
  output logic                  done_valid,
  output logic [TAG_W-1:0]      done_tag,
  output logic [LINE_AW-1:0]    done_line,
  output logic [LINE_BITS-1:0]  done_data
);
  logic [NUM_ENTRIES-1:0]  ent_valid, ent_issued;
  logic [LINE_AW-1:0]      ent_line [NUM_ENTRIES];
  logic [LINE_BYTES-1:0]   ent_mask [NUM_ENTRIES];
  logic [LINE_BITS-1:0]    ent_data [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0]  hit_vec, rsp_vec, free_vec, cand_vec;
  logic [NUM_ENTRIES-1:0]  alloc_vec, merge_vec, issue_vec;
  logic                    any_hit, any_free, any_cand, rsp_any;
  logic [TAG_W-1:0]        hit_idx, free_idx, cand_idx;
  logic                    st_accept, req_fire;

  // per-entry event wires
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_vec
    assign rsp_vec[i]  = rsp_valid && (rsp_tag == TAG_W'(i)) && ent_issued[i];
    assign hit_vec[i]  = ent_valid[i] && (ent_line[i] == st_line) && !rsp_vec[i];
    assign free_vec[i] = !ent_valid[i];
    assign cand_vec[i] = ent_valid[i] && !ent_issued[i];
  end

  smb_pick #(.N(NUM_ENTRIES)) u_hit  (.vec(hit_vec),  .any(any_hit),  .idx(hit_idx));
  smb_pick #(.N(NUM_ENTRIES)) u_free (.vec(free_vec), .any(any_free), .idx(free_idx));
  smb_pick #(.N(NUM_ENTRIES)) u_cand (.vec(cand_vec), .any(any_cand), .idx(cand_idx));

  assign st_stall  = st_valid && !any_hit && !any_free;
  assign st_accept = st_valid && !st_stall;
  assign req_valid = drain_en && any_cand;
  assign req_fire  = req_valid && req_ready;
  assign rsp_any   = |rsp_vec;

  assign req_tag       = cand_idx;
  assign req_line      = ent_line[cand_idx];
  assign req_addr_only = line_complete(ent_mask[cand_idx]);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    assign alloc_vec[i] = st_accept && !any_hit && (free_idx == TAG_W'(i));
    assign merge_vec[i] = st_accept && any_hit && (hit_idx == TAG_W'(i));
    assign issue_vec[i] = req_fire && (cand_idx == TAG_W'(i));
    smb_entry #(.LINE_AW(LINE_AW)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .alloc(alloc_vec[i]), .merge(merge_vec[i]),
      .issue(issue_vec[i]), .retire(rsp_vec[i]),
      .in_line(st_line), .in_be(st_be), .in_data(st_data),
      .q_valid(ent_valid[i]), .q_issued(ent_issued[i]),
      .q_line(ent_line[i]), .q_mask(ent_mask[i]), .q_data(ent_data[i]));
  end

  // completion: fill bytes only under unwritten positions
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid <= 1'b0;
      done_tag   <= '0;
      done_line  <= '0;
      done_data  <= '0;
    end else begin
      done_valid <= rsp_any;
      if (rsp_any) begin
        done_tag  <= rsp_tag;
        done_line <= ent_line[rsp_tag];
        done_data <= overlay_bytes(rsp_data, ent_data[rsp_tag], ent_mask[rsp_tag]);
      end
    end
  end

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R12
  AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    st_stall |-> (&ent_valid)); // R8
  AST_RSP_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (ent_valid[rsp_tag] && ent_issued[rsp_tag])); // R9
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> done_valid); // R11
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(rsp_valid)); // R11

  for (genvar a = 0; a < NUM_ENTRIES; a++) begin : g_ua
    for (genvar b = a + 1; b < NUM_ENTRIES; b++) begin : g_ub
      AST_UNIQUE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid[a] && ent_valid[b]) |-> (ent_line[a] != ent_line[b])); // R12
    end
  end
endmodule

// File: tb/test_smb_top.sv
module test_smb_top;
  localparam int AW = 27;
  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 0, drain_en = 0, req_ready = 0, rsp_valid = 0;
  logic [AW-1:0] st_line = '0;
  logic [31:0] st_be = '0;
  logic [255:0] st_data = '0, rsp_data = '0;
  logic [2:0] rsp_tag = '0;
  logic st_stall, req_valid, req_addr_only, done_valid;
  logic [2:0] req_tag, done_tag;
  logic [AW-1:0] req_line, done_line;
  logic [255:0] done_data;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  smb_top i_smb_top (.*);

  function automatic logic [255:0] pat(input logic [7:0] s);
    logic [255:0] r;
    for (int k = 0; k < 32; k++) r[8*k +: 8] = s + 8'(k);
    return r;
  endfunction

  // bench's own restatement: pick store byte where written, else keep old
  function automatic logic [255:0] lay(input logic [255:0] old, input logic [255:0] nw,
                                       input logic [31:0] be);
    logic [255:0] r;
    for (int k = 0; k < 32; k++) r[8*k +: 8] = be[k] ? nw[8*k +: 8] : old[8*k +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic store(input logic [AW-1:0] ln, input logic [31:0] be,
                       input logic [255:0] d, input bit exp_stall, input string req);
    @(negedge clk);
    st_valid = 1; st_line = ln; st_be = be; st_data = d;
    #1 check(st_stall == exp_stall, req, st_stall, exp_stall);
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic issue(input logic [2:0] tg, input logic [AW-1:0] ln, input bit ao,
                       input string req);
    @(negedge clk);
    drain_en = 1; req_ready = 1;
    #1;
    check(req_valid, req, req_valid, 1);
    check(req_tag == tg, req, req_tag, tg);
    check(req_line == ln, req, req_line, ln);
    check(req_addr_only == ao, req, req_addr_only, ao);
    @(negedge clk);
    drain_en = 0; req_ready = 0;
  endtask

  task automatic respond(input logic [2:0] tg, input logic [255:0] fill,
                         input logic [AW-1:0] ln, input bit chk_d,
                         input logic [255:0] exp_d, input string req);
    @(negedge clk);
    rsp_valid = 1; rsp_tag = tg; rsp_data = fill;
    @(negedge clk);
    rsp_valid = 0;
    check(done_valid, req, done_valid, 1);
    check(done_tag == tg, req, done_tag, tg);
    check(done_line == ln, req, done_line, ln);
    if (chk_d) check(done_data == exp_d, req, done_data, exp_d);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!req_valid && !done_valid && !st_stall, "R1", {req_valid, done_valid, st_stall}, 0);
    drain_en = 1; #1;
    check(!req_valid, "R1", req_valid, 0);
    drain_en = 0;
  endtask

  task automatic t_partial();
    logic [255:0] e;
    store(27'h100, 32'h0000000F, pat(8'h10), 0, "R2");
    store(27'h100, 32'h000001F8, pat(8'h40), 0, "R3");
    issue(3'd0, 27'h100, 0, "R6");
    @(negedge clk);
    drain_en = 1; #1;
    check(!req_valid, "R3", req_valid, 0);
    drain_en = 0;
    e = lay(lay(pat(8'hA0), pat(8'h10), 32'h0000000F), pat(8'h40), 32'h000001F8);
    respond(3'd0, pat(8'hA0), 27'h100, 1, e, "R4");
    @(negedge clk);
    check(!done_valid, "R11", done_valid, 0);
    store(27'h300, 32'h1, pat(8'h01), 0, "R11");
    issue(3'd0, 27'h300, 0, "R11");
    respond(3'd0, pat(8'h00), 27'h300, 1, lay(pat(8'h00), pat(8'h01), 32'h1), "R6");
  endtask

  task automatic t_full();
    logic [255:0] e;
    store(27'h200, 32'h0000FFFF, pat(8'h20), 0, "R3");
    store(27'h200, 32'hFFFF0000, pat(8'h60), 0, "R3");
    issue(3'd0, 27'h200, 1, "R5");
    e = lay(pat(8'h20), pat(8'h60), 32'hFFFF0000);
    respond(3'd0, pat(8'hEE), 27'h200, 1, e, "R7");
  endtask

  task automatic t_many();
    logic [255:0] e;
    for (int i = 0; i < 7; i++) store(27'h400 + AW'(i), 32'h1, pat(8'(i)), 0, "R2");
    store(27'h400, 32'h2, pat(8'h77), 0, "R12");
    store(27'h407, 32'h1, pat(8'h07), 0, "R12");
    store(27'h408, 32'h1, pat(8'h08), 1, "R8");
    store(27'h403, 32'h2, pat(8'h33), 0, "R8");
    @(negedge clk); #1;
    check(!req_valid, "R10", req_valid, 0);
    for (int i = 0; i < 8; i++) issue(3'(i), 27'h400 + AW'(i), 0, "R10");
    respond(3'd5, pat(8'h90), 27'h405, 0, '0, "R9");
    e = lay(lay(pat(8'hC0), pat(8'h03), 32'h1), pat(8'h33), 32'h2);
    respond(3'd3, pat(8'hC0), 27'h403, 1, e, "R9");
    respond(3'd7, pat(8'h90), 27'h407, 0, '0, "R9");
    respond(3'd0, pat(8'h90), 27'h400, 0, '0, "R9");
    respond(3'd6, pat(8'h90), 27'h406, 0, '0, "R9");
    respond(3'd1, pat(8'h90), 27'h401, 0, '0, "R9");
    respond(3'd4, pat(8'h90), 27'h404, 0, '0, "R9");
    respond(3'd2, pat(8'h90), 27'h402, 0, '0, "R9");
    // the stalled store to 0x408 must not exist
    @(negedge clk);
    drain_en = 1; #1;
    check(!req_valid, "R8", req_valid, 0);
    drain_en = 0;
  endtask

  initial begin
    t_reset();
    t_partial();
    t_full();
    t_many();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule